// File: doc/BRIEF.md
# Debounced Cycling Reference Selector

This block holds an 8-bit reference level and moves it to the next entry of a fixed six-step, non-linear list each time a mechanical pushbutton is pressed. The list runs 250, 180, 130, 100, 70, 40. A press on the last entry returns the level to the first.

The raw button first passes through a synchronizer. A sample-count debouncer then accepts a new button level only after several equal readings in a row. A one-shot turns each accepted press into a pulse one system clock wide. All stages advance only on a slow sampling enable. The block makes that enable itself by dividing the system clock, nominally down to 1 kHz.

A parent design reads the level (for example, as a timing reference). It can also use the press pulse to know when the level has just stepped.

Top module: `ref_stepper`

## Requirements
- R1: After reset `ref_val` is 250. Each accepted press moves it one step along 250, 180, 130, 100, 70, 40 in that order. `ref_val` never holds any other value.
- R2: An accepted press while `ref_val` is 40 sets it back to 250.
- R3: Each accepted press gives exactly one `press_pulse`, high for exactly one system clock. `ref_val` steps on the clock edge that follows that pulse and changes at no other time.
- R4: All stages advance only on a sampling enable that occurs once every `CLK_DIV` system clocks. The enable first fires `CLK_DIV` clocks after reset is released.
- R5: A new debounced level is accepted only after `DEB_SAMPLES` (default 4) consecutive enabled samples of the synchronized button equal that new level. A run of `DEB_SAMPLES-1` differing samples leaves the debounced level unchanged, and so causes no step and no pulse.
- R6: Holding the button down, or a short drop inside a hold, produces no further step. The next step needs an accepted release followed by an accepted press.
- R7: The button goes through `SYNC_STAGES` (default 2) synchronizer flops clocked on the enable. A clean press therefore raises `press_pulse` 6 enables after the first enable that captures it. That is between 6*`CLK_DIV`+1 and 7*`CLK_DIV` system clocks after the input rises.
- R8: Synchronous reset sets `ref_val` to 250 and clears the synchronizer, debouncer and one-shot. A button still held when reset ends is then treated as a fresh press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Asynchronous pushbutton level, 1 = pressed |
| ref_val | output | 8 | Current reference level |
| press_pulse | output | 1 | One-clock pulse for each accepted press |

## Verification
A clean press raises `press_pulse` 6 sampling enables after the first enable that captures the input. The bench drives the input one time step after a falling edge and measures the gap to the pulse in system clocks. Because the bench does not know where the input falls inside the enable period, it accepts the window 6*`CLK_DIV`+1 to 7*`CLK_DIV`. `ref_val` is due one clock after the pulse. The bench therefore compares it only after the hold and release periods have elapsed, which are several enables longer than that latency. The bounce cases hold the input for exactly `DEB_SAMPLES-1` enable periods. Any such window contains exactly that many enables, whatever its phase.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   localparam int SEQ_LEN = 6;
   localparam int REF_W   = 8;
   localparam int IDX_W   = $clog2(SEQ_LEN);

   typedef logic [IDX_W-1:0] idx_t;
   typedef logic [REF_W-1:0] ref_t;

   // level held at each list position
   function automatic ref_t level_at(idx_t i);
      case (i)
         IDX_W'(0): level_at = REF_W'(250);
         IDX_W'(1): level_at = REF_W'(180);
         IDX_W'(2): level_at = REF_W'(130);
         IDX_W'(3): level_at = REF_W'(100);
         IDX_W'(4): level_at = REF_W'(70);
         IDX_W'(5): level_at = REF_W'(40);
         default:   level_at = REF_W'(250);
      endcase
   endfunction

   // successor of a level in the list, wrapping at the end
   function automatic ref_t level_after(ref_t v);
      case (v)
         REF_W'(250): level_after = REF_W'(180);
         REF_W'(180): level_after = REF_W'(130);
         REF_W'(130): level_after = REF_W'(100);
         REF_W'(100): level_after = REF_W'(70);
         REF_W'(70):  level_after = REF_W'(40);
         default:     level_after = REF_W'(250);
      endcase
   endfunction
endpackage

// File: rtl/refsel_tick.sv
module refsel_tick #(
   parameter int CLK_DIV = 125000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

   logic [CW-1:0] cnt;

   assign tick = (cnt == CW'(CLK_DIV - 1));

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/refsel_debounce.sv
module refsel_debounce #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_SAMPLES = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic btn_raw,
   output logic level
);
   localparam int DCW = (DEB_SAMPLES > 2) ? $clog2(DEB_SAMPLES) : 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic [DCW-1:0]         run_cnt;
   logic                   sample;

   // synchronizer chain, one flop per stage, stepping on the enable
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst)       sync_q[0] <= 1'b0;
            else if (tick) sync_q[0] <= btn_raw;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst)       sync_q[s] <= 1'b0;
            else if (tick) sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign sample = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         level   <= 1'b0;
         run_cnt <= '0;
      end else if (tick) begin
         if (sample == level) begin
            run_cnt <= '0;
         end else if (run_cnt == DCW'(DEB_SAMPLES - 1)) begin
            level   <= sample;
            run_cnt <= '0;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/refsel_oneshot.sv
module refsel_oneshot (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic level,
   output logic pulse
);
   logic level_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         level_d <= 1'b0;
         pulse   <= 1'b0;
      end else if (tick) begin
         level_d <= level;
         pulse   <= level & ~level_d;
      end else begin
         pulse   <= 1'b0;
      end
   end
endmodule

// File: rtl/refsel_seq.sv
module refsel_seq
   import refsel_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic step,
   output ref_t ref_val
);
   idx_t idx;

   always_ff @(posedge clk) begin
      if (rst)
         idx <= '0;
      else if (step)
         idx <= (idx == IDX_W'(SEQ_LEN - 1)) ? '0 : idx + 1'b1;
   end

   assign ref_val = level_at(idx);
endmodule

// File: rtl/ref_stepper.sv
module ref_stepper
   import refsel_pkg::*;
#(
   parameter int CLK_DIV     = 125000,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_SAMPLES = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             btn_raw,
   output logic [REF_W-1:0] ref_val,
   output logic             press_pulse
);
   if (CLK_DIV < 2)     begin : g_bad_div  $error("CLK_DIV must be at least 2");     end
   if (SYNC_STAGES < 1) begin : g_bad_sync $error("SYNC_STAGES must be at least 1"); end
   if (DEB_SAMPLES < 2) begin : g_bad_deb  $error("DEB_SAMPLES must be at least 2"); end

   logic tick;
   logic deb_level;

   refsel_tick #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst(rst), .tick(tick)
   );

   refsel_debounce #(.SYNC_STAGES(SYNC_STAGES), .DEB_SAMPLES(DEB_SAMPLES)) u_deb (
      .clk(clk), .rst(rst), .tick(tick), .btn_raw(btn_raw), .level(deb_level)
   );

   refsel_oneshot u_shot (
      .clk(clk), .rst(rst), .tick(tick), .level(deb_level), .pulse(press_pulse)
   );

   refsel_seq u_seq (
      .clk(clk), .rst(rst), .step(press_pulse), .ref_val(ref_val)
   );
endmodule

// File: rtl/ref_stepper_chk.sv
module ref_stepper_chk
   import refsel_pkg::*;
(
   input logic             clk,
   input logic             rst,
   input logic [REF_W-1:0] ref_val,
   input logic             press_pulse
);
   AST_LEGAL_LEVEL: assert property (@(posedge clk) disable iff (rst)
      (ref_val == 8'd250 || ref_val == 8'd180 || ref_val == 8'd130 ||
       ref_val == 8'd100 || ref_val == 8'd70  || ref_val == 8'd40)); // R1

   AST_NEXT_LEVEL: assert property (@(posedge clk) disable iff (rst)
      press_pulse |=> ref_val == level_after($past(ref_val))); // R1

   AST_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
      (press_pulse && ref_val == 8'd40) |=> ref_val == 8'd250); // R2

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      press_pulse |=> !press_pulse); // R3

   AST_HOLD_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
      !press_pulse |=> $stable(ref_val)); // R3

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (ref_val == 8'd250 && !press_pulse)); // R8
endmodule

bind ref_stepper ref_stepper_chk u_chk (
   .clk(clk), .rst(rst), .ref_val(ref_val), .press_pulse(press_pulse)
);

// File: tb/sim_ref_stepper.sv
module sim_ref_stepper;
   localparam int DIV = 4;
   localparam int NS  = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       btn = 1'b0;
   logic [7:0] ref_val;
   logic       press_pulse;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int pulses = 0;
   int rise_cyc = 0;
   bit lat_pending = 0;
   bit last_pulse = 0;
   bit done = 0;
   int pos = 0;

   always #4 clk = ~clk;

   ref_stepper #(.CLK_DIV(DIV), .SYNC_STAGES(2), .DEB_SAMPLES(NS)) u0 (
      .clk(clk), .rst(rst), .btn_raw(btn), .ref_val(ref_val), .press_pulse(press_pulse)
   );

   function automatic int expect_level(int p);
      int v;
      v = 250;
      if (p % 6 == 1) v = 180;
      if (p % 6 == 2) v = 130;
      if (p % 6 == 3) v = 100;
      if (p % 6 == 4) v = 70;
      if (p % 6 == 5) v = 40;
      return v;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor on falling edges: pulse width, count and latency
   always @(negedge clk) begin
      cyc++;
      if (!rst && press_pulse) begin
         pulses++;
         if (lat_pending) begin
            lat_pending = 0;
            checks++;
            if (cyc - rise_cyc < 6*DIV + 1 || cyc - rise_cyc > 7*DIV) begin
               errors++;
               $display("FAIL R7 R4 actual latency %0d expected %0d..%0d",
                        cyc - rise_cyc, 6*DIV + 1, 7*DIV);
            end
         end
      end
      if (!rst && press_pulse && last_pulse) begin
         checks++; errors++;
         $display("FAIL R3 actual pulse width 2 expected 1");
      end
      last_pulse = press_pulse;
   end

   task automatic wait_ticks(int n);
      repeat (n*DIV) @(negedge clk);
      #1;
   endtask

   task automatic set_btn(bit v, bit timed);
      @(negedge clk); #1;
      btn = v;
      if (timed) begin rise_cyc = cyc; lat_pending = 1; end
   endtask

   task automatic press(int hold, int rel);
      int p0;
      p0 = pulses;
      set_btn(1'b1, 1'b1);
      wait_ticks(hold);
      btn = 1'b0;
      wait_ticks(rel);
      pos++;
      check("R3", pulses - p0, 1);
      check("R1 R2", ref_val, expect_level(pos));
   endtask

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      #1;
      check("R8", ref_val, 250);
      check("R8", press_pulse, 0);
      rst = 1'b0;
      wait_ticks(3);
      check("R1", ref_val, 250);

      // full sweep through the list, twice round plus one
      for (int i = 0; i < 13; i++) press(10 + (i % 3), 10);

      // bounce shorter than the debounce count
      p0 = pulses;
      set_btn(1'b1, 1'b0);
      repeat ((NS-1)*DIV) @(negedge clk);
      #1; btn = 1'b0;
      wait_ticks(12);
      check("R5", pulses - p0, 0);
      check("R5", ref_val, expect_level(pos));

      // long hold with a short drop inside it
      p0 = pulses;
      set_btn(1'b1, 1'b1);
      wait_ticks(30);
      btn = 1'b0;
      repeat ((NS-1)*DIV) @(negedge clk);
      #1; btn = 1'b1;
      wait_ticks(30);
      btn = 1'b0;
      wait_ticks(12);
      pos++;
      check("R6", pulses - p0, 1);
      check("R6", ref_val, expect_level(pos));

      // exactly the debounce count is accepted
      press(NS, 12);

      // reset while held: back to 250, held button counts afresh
      set_btn(1'b1, 1'b0);
      wait_ticks(12);
      @(negedge clk); #1; rst = 1'b1;
      @(negedge clk); #1;
      check("R8", ref_val, 250);
      @(negedge clk); #1; rst = 1'b0;
      wait_ticks(12);
      check("R8", ref_val, 180);
      btn = 1'b0;
      wait_ticks(12);
      check("R8", ref_val, 180);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule